// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block moves outgoing frame data under the control of a circular list of transmit descriptors. The descriptors live in a small memory inside the block. Software loads them through a write port and can inspect them through a read port. Each descriptor names a byte buffer in an external memory, gives a byte count and carries ownership and framing flags. The engine takes descriptors in index order and streams each owned buffer one byte at a time over a valid/ready port. It marks the end of a frame and whether a checksum should be appended. When a descriptor is finished, the engine hands it back to software by clearing its ownership flag.

Software controls the engine with a small write-only register port. The engine stops by itself when it reaches a descriptor that software does not yet own. A write-one-to-clear on the halt bit restarts it at that same index. A graceful stop request lets the frame in flight finish and then parks the engine. Sticky event bits report completed descriptors, completed frames and the end of a graceful stop, and a masked OR of those bits drives one interrupt line.

Top module: `txr_ring_engine`

## Requirements
- R1: A descriptor is a 48-bit word {pointer[47:32], length[31:16], flags[15:0]}, with flag bits ready=0, wrap=1, interrupt=2, last=3, crc=4. For a ready descriptor, the engine sends `length` bytes read from consecutive buffer addresses starting at `pointer`, in order, on `tx_data`.
- R2: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data`, `tx_eof` and `tx_crc` hold their values.
- R3: `tx_eof` is high only on the final byte of a descriptor whose last flag is set. A frame may span several descriptors.
- R4: `tx_crc` is high only together with `tx_eof`, and only when the last descriptor of the frame has its crc flag set.
- R5: A ready descriptor of length zero is completed and handed back without sending any byte.
- R6: On completion, the engine writes the descriptor back with the ready flag cleared and the pointer, length, wrap flag and other flags unchanged.
- R7: After a descriptor whose wrap flag is set, the next index is 0. Otherwise it is the current index plus one.
- R8: The halt status is set by reset and whenever the engine fetches a descriptor without the ready flag. No bytes are sent while it is set. Writing 1 to bit 0 at register address 1 clears it, and fetching resumes at the index where the engine stopped.
- R9: Bit 0 at register address 0 requests a graceful stop. The frame in progress finishes, no further descriptor is fetched, and event bit 2 is raised. Writing 0 to the bit lets transmission resume.
- R10: Event bits at register address 2 are sticky: bit 0 is set per completed descriptor, bit 1 per completed frame whose last descriptor has the interrupt flag, and bit 2 on graceful-stop completion. Writing 1 to a bit clears it.
- R11: `irq` is the OR of the event bits ANDed with the mask written at register address 3.
- R12: After reset, `halted` is 1, and `events`, `irq` and `tx_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dsc_we | input | 1 | Software descriptor write strobe |
| dsc_waddr | input | IDX_W | Descriptor index to write |
| dsc_wdata | input | DESC_W | Descriptor word to write |
| dsc_raddr | input | IDX_W | Descriptor index to read |
| dsc_rdata | output | DESC_W | Descriptor word, one cycle after dsc_raddr |
| reg_we | input | 1 | Control register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 3 | Register write data |
| buf_addr | output | PTR_W | Buffer byte address |
| buf_data | input | 8 | Buffer byte at buf_addr, same cycle |
| tx_valid | output | 1 | Byte available |
| tx_ready | input | 1 | Sink accepts byte |
| tx_data | output | 8 | Byte |
| tx_eof | output | 1 | Final byte of frame |
| tx_crc | output | 1 | Append-checksum request with final byte |
| halted | output | 1 | Halt status |
| events | output | 3 | Sticky event bits |
| irq | output | 1 | Masked interrupt |

## Verification
The checker watches the output port on every cycle. It confirms that a stalled byte holds steady with its flags, that a checksum request never appears without end-of-frame, and that no new byte starts while halted. It also confirms that the halt bit and each event bit fall only after a matching write-one-to-clear. Byte order, the placement of end-of-frame across multi-descriptor frames, zero-length hand-back, write-back contents, wrap to index 0, restart at the stopped index and the graceful stop finishing a frame can only be shown by the bench. Its reference queue and descriptor read-backs cover these cases.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int FLG_W   = 16;
  localparam int FB_RDY  = 0;
  localparam int FB_WRAP = 1;
  localparam int FB_INT  = 2;
  localparam int FB_LAST = 3;
  localparam int FB_CRC  = 4;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_STAT = 2'd1;
  localparam logic [1:0] RA_EVT  = 2'd2;
  localparam logic [1:0] RA_MASK = 2'd3;

  localparam int EV_W   = 3;
  localparam int EV_BUF = 0;
  localparam int EV_FRM = 1;
  localparam int EV_GSC = 2;

  typedef enum logic [2:0] {S_FETCH, S_DECODE, S_REQ, S_SEND, S_WB} eng_state_t;
endpackage

// File: rtl/txr_desc_mem.sv
module txr_desc_mem #(
  parameter int DEPTH = 8,
  parameter int W     = 48,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra_a,
  output logic [W-1:0]  qa,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  qb
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    qa <= mem[ra_a];
    qb <= mem[ra_b];
  end
endmodule

// File: rtl/txr_regs.sv
module txr_regs
  import txr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic [1:0]      reg_addr,
  input  logic [EV_W-1:0] reg_wdata,
  input  logic            halt_set,
  input  logic [EV_W-1:0] ev_set,
  output logic            gstop_req,
  output logic            halted,
  output logic [EV_W-1:0] events,
  output logic            irq
);
  logic [EV_W-1:0] mask_q;
  logic            stat_w1c;
  logic [EV_W-1:0] ev_clr;

  assign stat_w1c = reg_we && (reg_addr == RA_STAT) && reg_wdata[0];
  assign ev_clr   = (reg_we && (reg_addr == RA_EVT)) ? reg_wdata : '0;
  assign irq      = |(events & mask_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      gstop_req <= 1'b0;
      halted    <= 1'b1;
      events    <= '0;
      mask_q    <= '0;
    end else begin
      if (reg_we && reg_addr == RA_CTRL) gstop_req <= reg_wdata[0];
      if (reg_we && reg_addr == RA_MASK) mask_q <= reg_wdata;
      halted <= halt_set | (halted & ~stat_w1c);
      events <= ev_set | (events & ~ev_clr);
    end
  end
endmodule

// File: rtl/txr_engine.sv
module txr_engine
  import txr_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LEN_W = 16,
  parameter int PTR_W = 16,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int DESC_W = FLG_W + LEN_W + PTR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halted,
  input  logic              gstop_req,
  input  logic              sw_wr_busy,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [DESC_W-1:0] rd_q,
  output logic              wb_we,
  output logic [DESC_W-1:0] wb_data,
  output logic [PTR_W-1:0]  buf_addr,
  input  logic [7:0]        buf_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_eof,
  output logic              tx_crc,
  output logic              halt_set,
  output logic [EV_W-1:0]   ev_set
);
  eng_state_t        state;
  logic [IDX_W-1:0]  idx;
  logic [DESC_W-1:0] cur;
  logic [LEN_W-1:0]  cnt;
  logic              in_frame;
  logic              gs_done;
  logic              last_byte;
  logic [LEN_W-1:0]  q_len;
  logic [PTR_W-1:0]  q_ptr;

  assign rd_idx    = idx;
  assign q_len     = rd_q[FLG_W +: LEN_W];
  assign q_ptr     = rd_q[FLG_W+LEN_W +: PTR_W];
  assign last_byte = (cnt == LEN_W'(1));

  always_comb begin
    halt_set        = (state == S_DECODE) && !rd_q[FB_RDY];
    wb_we           = (state == S_WB) && !sw_wr_busy;
    wb_data         = cur;
    wb_data[FB_RDY] = 1'b0;
    ev_set          = '0;
    ev_set[EV_BUF]  = wb_we;
    ev_set[EV_FRM]  = wb_we && cur[FB_LAST] && cur[FB_INT];
    ev_set[EV_GSC]  = (state == S_FETCH) && gstop_req && !in_frame && !gs_done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_FETCH;
      idx      <= '0;
      cur      <= '0;
      cnt      <= '0;
      in_frame <= 1'b0;
      gs_done  <= 1'b0;
      buf_addr <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
      tx_eof   <= 1'b0;
      tx_crc   <= 1'b0;
    end else begin
      case (state)
        S_FETCH: begin
          if (!gstop_req) gs_done <= 1'b0;
          if (gstop_req && !in_frame) gs_done <= 1'b1;
          else if (!halted) state <= S_DECODE;
        end
        S_DECODE: begin
          if (!rd_q[FB_RDY]) begin
            state <= S_FETCH;
          end else begin
            cur      <= rd_q;
            cnt      <= q_len;
            buf_addr <= q_ptr;
            state    <= (q_len == '0) ? S_WB : S_REQ;
          end
        end
        S_REQ: begin
          tx_data  <= buf_data;
          tx_valid <= 1'b1;
          tx_eof   <= last_byte && cur[FB_LAST];
          tx_crc   <= last_byte && cur[FB_LAST] && cur[FB_CRC];
          state    <= S_SEND;
        end
        S_SEND: begin
          if (tx_ready) begin
            tx_valid <= 1'b0;
            tx_eof   <= 1'b0;
            tx_crc   <= 1'b0;
            cnt      <= cnt - LEN_W'(1);
            buf_addr <= buf_addr + PTR_W'(1);
            state    <= last_byte ? S_WB : S_REQ;
          end
        end
        S_WB: begin
          if (!sw_wr_busy) begin
            in_frame <= !cur[FB_LAST];
            if (cur[FB_WRAP] || idx == IDX_W'(DEPTH - 1)) idx <= '0;
            else idx <= idx + IDX_W'(1);
            state <= S_FETCH;
          end
        end
        default: state <= S_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/txr_ring_engine.sv
module txr_ring_engine
  import txr_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LEN_W = 16,
  parameter int PTR_W = 16,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int DESC_W = FLG_W + LEN_W + PTR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dsc_we,
  input  logic [IDX_W-1:0]  dsc_waddr,
  input  logic [DESC_W-1:0] dsc_wdata,
  input  logic [IDX_W-1:0]  dsc_raddr,
  output logic [DESC_W-1:0] dsc_rdata,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [EV_W-1:0]   reg_wdata,
  output logic [PTR_W-1:0]  buf_addr,
  input  logic [7:0]        buf_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_eof,
  output logic              tx_crc,
  output logic              halted,
  output logic [EV_W-1:0]   events,
  output logic              irq
);
  logic              gstop_req, halt_set, eng_wb_we;
  logic [EV_W-1:0]   ev_set;
  logic [IDX_W-1:0]  eng_idx;
  logic [DESC_W-1:0] eng_q, eng_wb_data;
  logic              mem_we;
  logic [IDX_W-1:0]  mem_waddr;
  logic [DESC_W-1:0] mem_wdata;

  assign mem_we    = dsc_we | eng_wb_we;
  assign mem_waddr = dsc_we ? dsc_waddr : eng_idx;
  assign mem_wdata = dsc_we ? dsc_wdata : eng_wb_data;

  txr_desc_mem #(.DEPTH(DEPTH), .W(DESC_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .ra_a(eng_idx), .qa(eng_q), .ra_b(dsc_raddr), .qb(dsc_rdata)
  );

  txr_regs u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .halt_set(halt_set), .ev_set(ev_set),
    .gstop_req(gstop_req), .halted(halted), .events(events), .irq(irq)
  );

  txr_engine #(.DEPTH(DEPTH), .LEN_W(LEN_W), .PTR_W(PTR_W)) u_eng (
    .clk(clk), .rst(rst), .halted(halted), .gstop_req(gstop_req),
    .sw_wr_busy(dsc_we), .rd_idx(eng_idx), .rd_q(eng_q),
    .wb_we(eng_wb_we), .wb_data(eng_wb_data), .buf_addr(buf_addr),
    .buf_data(buf_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_eof(tx_eof), .tx_crc(tx_crc),
    .halt_set(halt_set), .ev_set(ev_set)
  );
endmodule

// File: rtl/txr_ring_engine_chk.sv
module txr_ring_engine_chk
  import txr_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            tx_valid,
  input logic            tx_ready,
  input logic [7:0]      tx_data,
  input logic            tx_eof,
  input logic            tx_crc,
  input logic            halted,
  input logic [EV_W-1:0] events,
  input logic            reg_we,
  input logic [1:0]      reg_addr,
  input logic [EV_W-1:0] reg_wdata
);
  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_eof) && $stable(tx_crc)));

  // R4
  crc_with_eof_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_crc) |-> tx_eof);

  // R8
  no_start_halted_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid) |-> !halted);

  // R8
  halt_clear_w1c_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(halted) |-> $past(reg_we && reg_addr == RA_STAT && reg_wdata[0]));

  for (genvar i = 0; i < EV_W; i++) begin : g_ev
    // R10
    event_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(events[i]) |-> $past(reg_we && reg_addr == RA_EVT && reg_wdata[i]));
  end
endmodule

bind txr_ring_engine txr_ring_engine_chk u_chk (
  .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_eof(tx_eof), .tx_crc(tx_crc), .halted(halted),
  .events(events), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/txr_ring_engine_tb_top.sv
`timescale 1ns/1ps
module txr_ring_engine_tb_top;
  localparam int DEPTH = 8;
  localparam int IDX_W = 3;
  localparam int DW    = 48;

  logic clk = 1'b0, rst = 1'b1;
  logic dsc_we = 1'b0;
  logic [IDX_W-1:0] dsc_waddr = '0, dsc_raddr = '0;
  logic [DW-1:0] dsc_wdata = '0, dsc_rdata;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [2:0] reg_wdata = '0;
  logic [15:0] buf_addr;
  logic [7:0] buf_data, tx_data;
  logic tx_valid, tx_ready = 1'b0, tx_eof, tx_crc, halted, irq;
  logic [2:0] events;

  int checks = 0, fails = 0, cyc = 0, rdy_mode = 0;
  bit done = 0;
  logic [9:0] expq[$];

  always #2 clk = ~clk;

  function automatic logic [7:0] bval(input logic [15:0] a);
    return 8'((int'(a) * 37 + 11) & 255);
  endfunction
  assign buf_data = bval(buf_addr);

  function automatic logic [DW-1:0] mk(input logic [15:0] p, input logic [15:0] l, input logic [15:0] f);
    return {p, l, f};
  endfunction

  txr_ring_engine #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .dsc_we(dsc_we), .dsc_waddr(dsc_waddr), .dsc_wdata(dsc_wdata),
    .dsc_raddr(dsc_raddr), .dsc_rdata(dsc_rdata), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .buf_addr(buf_addr), .buf_data(buf_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_eof(tx_eof), .tx_crc(tx_crc),
    .halted(halted), .events(events), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // reference stream comparison, every clock
  always @(negedge clk) begin
    cyc++;
    case (rdy_mode)
      0: tx_ready = 1'b0;
      1: tx_ready = 1'b1;
      default: tx_ready = (cyc % 3) != 0;
    endcase
    if (!rst && tx_valid && tx_ready) begin
      if (expq.size() == 0) begin
        chk(0, "R1 unexpected byte", {54'd0, tx_data, tx_eof, tx_crc}, 0);
      end else begin
        logic [9:0] e;
        e = expq.pop_front();
        chk(tx_data == e[9:2], "R1 data", tx_data, e[9:2]);
        chk(tx_eof == e[1], "R3 eof", tx_eof, e[1]);
        chk(tx_crc == e[0], "R4 crc", tx_crc, e[0]);
      end
    end
  end

  always @(posedge clk) begin
    if (!done && cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      summary();
      $finish;
    end
  end

  task automatic push_bytes(input logic [15:0] p, input int len, input bit last, input bit crc);
    for (int k = 0; k < len; k++)
      expq.push_back({bval(p + 16'(k)), last && k == len - 1, crc && last && k == len - 1});
  endtask

  task automatic wr_desc(input int i, input logic [DW-1:0] d);
    dsc_we = 1'b1; dsc_waddr = IDX_W'(i); dsc_wdata = d;
    @(negedge clk);
    dsc_we = 1'b0;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [2:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_desc(input int i, output logic [DW-1:0] d);
    dsc_raddr = IDX_W'(i);
    @(negedge clk);
    d = dsc_rdata;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!(halted && expq.size() == 0) && n < 3000) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    logic [DW-1:0] d;
    int n;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(halted == 1'b1, "R12 halted", halted, 1);
    chk(events == 3'b000, "R12 events", events, 0);
    chk(irq == 1'b0, "R12 irq", irq, 0);
    chk(tx_valid == 1'b0, "R12 tx_valid", tx_valid, 0);
    repeat (10) @(negedge clk);
    chk(tx_valid == 1'b0, "R8 no bytes while halted", tx_valid, 0);

    // multi-descriptor frame, zero-length entry, wrap on entry 3, backpressure
    rdy_mode = 2;
    wr_desc(0, mk(16'h0010, 16'd3, 16'h0001));
    wr_desc(1, mk(16'h0040, 16'd2, 16'h001D));
    wr_desc(2, mk(16'h0080, 16'd0, 16'h0001));
    wr_desc(3, mk(16'h0090, 16'd4, 16'h000B));
    push_bytes(16'h0010, 3, 0, 0);
    push_bytes(16'h0040, 2, 1, 1);
    push_bytes(16'h0090, 4, 1, 0);
    wr_reg(2'd1, 3'b001);
    wait_done();
    chk(expq.size() == 0, "R1 all bytes sent", expq.size(), 0);
    chk(halted == 1'b1, "R8 halt on non-ready", halted, 1);
    chk(events == 3'b011, "R10 buf+frame events", events, 3'b011);
    rd_desc(0, d); chk(d == mk(16'h0010, 16'd3, 16'h0000), "R6 desc0 handed back", d, mk(16'h0010, 16'd3, 16'h0000));
    rd_desc(1, d); chk(d == mk(16'h0040, 16'd2, 16'h001C), "R6 desc1 handed back", d, mk(16'h0040, 16'd2, 16'h001C));
    rd_desc(2, d); chk(d == mk(16'h0080, 16'd0, 16'h0000), "R5 zero-length handed back", d, mk(16'h0080, 16'd0, 16'h0000));
    rd_desc(3, d); chk(d == mk(16'h0090, 16'd4, 16'h000A), "R6 wrap kept", d, mk(16'h0090, 16'd4, 16'h000A));

    // R11 masking and R10 W1C per bit
    chk(irq == 1'b0, "R11 masked off", irq, 0);
    wr_reg(2'd3, 3'b010);
    chk(irq == 1'b1, "R11 frame unmasked", irq, 1);
    wr_reg(2'd2, 3'b010);
    chk(events == 3'b001, "R10 w1c one bit", events, 3'b001);
    chk(irq == 1'b0, "R11 after clear", irq, 0);
    wr_reg(2'd2, 3'b001);
    chk(events == 3'b000, "R10 w1c buf", events, 0);

    // R7 wrap to index 0, R8 restart at stopped index
    wr_desc(0, mk(16'h0020, 16'd2, 16'h000D));
    push_bytes(16'h0020, 2, 1, 0);
    wr_reg(2'd1, 3'b001);
    chk(halted == 1'b0, "R8 w1c clears halt", halted, 0);
    wait_done();
    chk(expq.size() == 0, "R7 resumed at index 0", expq.size(), 0);
    chk(events == 3'b011, "R10 events after restart", events, 3'b011);
    chk(irq == 1'b1, "R11 irq asserted", irq, 1);
    wr_reg(2'd2, 3'b011);

    // R9 graceful stop mid-frame
    rdy_mode = 0;
    wr_desc(1, mk(16'h0030, 16'd6, 16'h0001));
    wr_desc(2, mk(16'h0050, 16'd3, 16'h0009));
    wr_desc(3, mk(16'h0060, 16'd2, 16'h000B));
    push_bytes(16'h0030, 6, 0, 0);
    push_bytes(16'h0050, 3, 1, 0);
    wr_reg(2'd1, 3'b001);
    n = 0;
    while (!tx_valid && n < 200) begin @(negedge clk); n++; end
    wr_reg(2'd0, 3'b001);
    chk(events[2] == 1'b0, "R9 no stop event mid-frame", events[2], 0);
    rdy_mode = 1;
    repeat (300) @(negedge clk);
    chk(expq.size() == 0, "R9 frame finished", expq.size(), 0);
    chk(events[2] == 1'b1, "R9 stop-complete event", events[2], 1);
    chk(halted == 1'b0 && tx_valid == 1'b0, "R9 parked not halted", {halted, tx_valid}, 0);
    rd_desc(3, d); chk(d == mk(16'h0060, 16'd2, 16'h000B), "R9 next desc untouched", d, mk(16'h0060, 16'd2, 16'h000B));
    push_bytes(16'h0060, 2, 1, 0);
    wr_reg(2'd0, 3'b000);
    wait_done();
    chk(expq.size() == 0, "R9 resume after clear", expq.size(), 0);
    chk(halted == 1'b1, "R7 halted after wrap", halted, 1);

    done = 1;
    summary();
    $finish;
  end
endmodule